// File: doc/BRIEF.md
# Serial Clock Synthesizer Word Loader

This block programs an external frequency synthesizer over a two-wire serial link. When a start pulse is accepted, it captures a set of divider settings: a 7-bit feedback count, a 7-bit reference count, a VCO range flag, a prescale flag and a 2-bit output divider select. It packs them into one 24-bit programming word and shifts that word out, least significant bit first, with one bit for each period of the serial clock.

While the last bit is on the line, a load strobe is raised beside it. After the 24th bit the block issues a single-cycle commit pulse, during which the data, clock and load lines are all low; this pulse tells the synthesizer to adopt the new setting. A busy flag covers the whole transfer. Start pulses that arrive while busy are dropped. The serial clock speed is set per transfer by a hold count that is captured with the parameters.

Top module: `synth_word_loader`

## Requirements
- R1: The word carries the feedback count in bits 6:0, the reference count in bits 13:7, the range flag in bit 14 and the prescale flag in bit 15. The divider select occupies bits 18:17.
- R2: Bits 23:19 of the word are the constant 0x17, and bit 16 is 0.
- R3: Exactly 24 bits are sent, starting at bit 0, one bit for each serial clock period.
- R4: With a captured hold count h, every bit spends h+1 system clocks with the serial clock low, followed by h+1 clocks with it high. The low phase of bit 0 begins in the cycle after the accepting edge.
- R5: The serial data output changes only while the serial clock is low.
- R6: The load strobe is high for the entire final bit (bit 23) and is low at every other time.
- R7: In the cycle after the final bit's high phase ends, the commit output is high for exactly one cycle, with data, clock and load all low.
- R8: The busy flag rises in the cycle after a start is accepted, stays high through the commit cycle and falls in the cycle after it.
- R9: A start pulse received while busy is high, including during the commit cycle, has no effect on the transfer in progress.
- R10: The parameters and the hold count are sampled when the start is accepted. Changes to them later in the transfer do not alter it.
- R11: While reset is asserted, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| n_i | input | 7 | Feedback divider count |
| m_i | input | 7 | Reference divider count |
| v_i | input | 1 | VCO range flag |
| x_i | input | 1 | Prescale flag |
| r_i | input | 2 | Output divider select |
| hold_i | input | HOLD_W | Half-period length minus one, in system clocks |
| sdata_o | output | 1 | Serial data |
| sclk_o | output | 1 | Serial clock |
| load_o | output | 1 | Load strobe, driven during the last bit |
| commit_o | output | 1 | One-cycle commit pulse |
| busy_o | output | 1 | Transfer in progress |

## Verification
On every cycle, the assertions check these behaviours: the data line stays still while the clock is high, the commit cycle comes straight after the load strobe ends and lasts one cycle, busy holds until the commit, a start seen while busy leaves the captured hold count unchanged, and the phase counter stays within its bound. Whether each bit has the correct value and position, whether the phase lengths are right and whether the parameters were captured at the proper moment can only be shown by the bench. It does this by comparing every output cycle by cycle against a word and a schedule computed from the inputs, across several hold counts and parameter patterns. In the same runs it changes the inputs and sends start pulses partway through transfers.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam int N_W     = 7;
  localparam int M_W     = 7;
  localparam int R_W     = 2;
  localparam int CONST_W = 5;
  localparam int WORD_W  = CONST_W + R_W + 1 + 1 + 1 + M_W + N_W;
  localparam int BIT_W   = $clog2(WORD_W);
  localparam logic [CONST_W-1:0] SYNC_CONST = 5'h17;

  typedef struct packed {
    logic [R_W-1:0] r;
    logic           x;
    logic           v;
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } div_params_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_COMMIT = 2'd2
  } ld_state_e;
endpackage

// File: rtl/swl_word_pack.sv
module swl_word_pack
  import swl_pkg::*;
(
  input  div_params_t       params_i,
  output logic [WORD_W-1:0] word_o
);
  // R1/R2: constant field on top, reserved zero at bit 16
  assign word_o = {SYNC_CONST, params_i.r, 1'b0, params_i.x, params_i.v,
                   params_i.m, params_i.n};
endmodule

// File: rtl/swl_half_timer.sv
module swl_half_timer #(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              tick_o
);
  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign tick_o = run_i && (cnt_q == hold_i);
  assign cnt_en = run_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= hold_i));
endmodule

// File: rtl/swl_shift_ctrl.sv
module swl_shift_ctrl
  import swl_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              tick_i,
  output logic              run_o,
  output logic [HOLD_W-1:0] hold_q_o,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic              load_o,
  output logic              commit_o,
  output logic              busy_o
);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(WORD_W - 1);

  ld_state_e         state_q, state_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [BIT_W-1:0]  idx_q, idx_d;
  logic              phase_q, phase_d;
  logic [HOLD_W-1:0] hold_q;
  logic              accept;

  assign accept = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    idx_d   = idx_q;
    phase_d = phase_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SHIFT;
          shreg_d = word_i;
          idx_d   = '0;
          phase_d = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (tick_i) begin
          if (!phase_q) begin
            phase_d = 1'b1;
          end else if (idx_q == LAST_IDX) begin
            phase_d = 1'b0;
            state_d = ST_COMMIT;
          end else begin
            phase_d = 1'b0;
            idx_d   = idx_q + 1'b1;
            shreg_d = shreg_q >> 1;
          end
        end
      end
      ST_COMMIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      idx_q   <= idx_d;
      phase_q <= phase_d;
    end
  end

  // R10: hold count captured only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (accept) hold_q <= hold_i;
  end

  assign run_o    = (state_q == ST_SHIFT);
  assign hold_q_o = hold_q;
  assign sclk_o   = run_o && phase_q;
  assign sdata_o  = run_o && shreg_q[0];
  assign load_o   = run_o && (idx_q == LAST_IDX);
  assign commit_o = (state_q == ST_COMMIT);
  assign busy_o   = (state_q != ST_IDLE);

  p_data_quiet_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
  p_commit_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_o) |-> commit_o);
  p_commit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (!commit_o && !busy_o));
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !commit_o) |=> busy_o);
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> $stable(hold_q));
  p_load_not_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> !commit_o);
endmodule

// File: rtl/synth_word_loader.sv
module synth_word_loader
  import swl_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [N_W-1:0]    n_i,
  input  logic [M_W-1:0]    m_i,
  input  logic              v_i,
  input  logic              x_i,
  input  logic [R_W-1:0]    r_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic              load_o,
  output logic              commit_o,
  output logic              busy_o
);
  div_params_t       params;
  logic [WORD_W-1:0] word;
  logic              run, tick;
  logic [HOLD_W-1:0] hold_q;

  assign params = '{r: r_i, x: x_i, v: v_i, m: m_i, n: n_i};

  swl_word_pack u_pack (
    .params_i (params),
    .word_o   (word)
  );

  swl_shift_ctrl #(.HOLD_W(HOLD_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .word_i   (word),
    .hold_i   (hold_i),
    .tick_i   (tick),
    .run_o    (run),
    .hold_q_o (hold_q),
    .sdata_o  (sdata_o),
    .sclk_o   (sclk_o),
    .load_o   (load_o),
    .commit_o (commit_o),
    .busy_o   (busy_o)
  );

  swl_half_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .hold_i (hold_q),
    .tick_o (tick)
  );
endmodule

// File: tb/synth_word_loader_bench.sv
module synth_word_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD_W     = 4;
  localparam int WATCHDOG   = 150000;

  logic clk, rst_n, start_i, v_i, x_i;
  logic [6:0] n_i, m_i;
  logic [1:0] r_i;
  logic [HOLD_W-1:0] hold_i;
  logic sdata_o, sclk_o, load_o, commit_o, busy_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  synth_word_loader #(.HOLD_W(HOLD_W)) u_synth_word_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .n_i(n_i), .m_i(m_i),
    .v_i(v_i), .x_i(x_i), .r_i(r_i), .hold_i(hold_i), .sdata_o(sdata_o),
    .sclk_o(sclk_o), .load_o(load_o), .commit_o(commit_o), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired act=%0d exp<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_word(input logic [6:0] n, input logic [6:0] m,
                                           input logic v, input logic x, input logic [1:0] r);
    logic [23:0] w;
    w = '0;
    w[6:0]   = n;
    w[13:7]  = m;
    w[14]    = v;
    w[15]    = x;
    w[18:17] = r;
    w[23:19] = 5'h17;
    return w;
  endfunction

  // mode bit0: start pulse mid-transfer, bit1: start pulse in commit cycle
  task automatic run_xfer(input logic [6:0] n, input logic [6:0] m, input logic v,
                          input logic x, input logic [1:0] r,
                          input logic [HOLD_W-1:0] h, input int mode);
    logic [23:0] w, recon;
    int hc, last, nbits, err0, quiet_viol;
    logic prev_sclk, prev_sdata;
    w = exp_word(n, m, v, x, r);
    hc = int'(h) + 1;
    last = 48 * hc;
    recon = '0;
    nbits = 0;
    quiet_viol = 0;
    prev_sclk = 1'b0;
    prev_sdata = 1'b0;
    err0 = errors;
    n_i = n; m_i = m; v_i = v; x_i = x; r_i = r; hold_i = h;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n_i = ~n; m_i = ~m; v_i = ~v; x_i = ~x; r_i = ~r; hold_i = ~h;  // R10
    for (int c = 0; c <= last + 1; c++) begin
      logic e_sclk, e_sdata, e_load, e_commit, e_busy;
      if (c < last) begin
        int k;
        k = c / (2 * hc);
        e_sclk   = ((c % (2 * hc)) >= hc);
        e_sdata  = w[k];
        e_load   = (k == 23);
        e_commit = 1'b0;
        e_busy   = 1'b1;
      end else begin
        e_sclk = 1'b0; e_sdata = 1'b0; e_load = 1'b0;
        e_commit = (c == last);
        e_busy   = (c == last);
      end
      chk("R4 sclk", 32'(sclk_o), 32'(e_sclk));
      chk("R3 sdata bit order", 32'(sdata_o), 32'(e_sdata));
      chk("R6 load", 32'(load_o), 32'(e_load));
      chk("R7 commit", 32'(commit_o), 32'(e_commit));
      chk("R8 busy", 32'(busy_o), 32'(e_busy));
      if (sclk_o && !prev_sclk && nbits < 24) begin
        recon[nbits] = sdata_o;
        nbits++;
      end
      if (sclk_o && prev_sclk && (sdata_o !== prev_sdata)) quiet_viol++;
      prev_sclk = sclk_o;
      prev_sdata = sdata_o;
      start_i = 1'b0;
      if ((mode & 1) != 0 && (c == 3 || c == last / 2)) start_i = 1'b1;
      if ((mode & 2) != 0 && c == last) start_i = 1'b1;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R3 bit count", 32'(nbits), 32'd24);
    chk("R1 recovered word", 32'(recon), 32'(w));
    chk("R2 constant field", 32'(recon[23:19]), 32'h17);
    chk("R2 bit16 zero", 32'(recon[16]), 32'h0);
    chk("R5 data still while sclk high", 32'(quiet_viol), 32'd0);
    chk("R10 transfer unaffected by input changes", 32'(errors - err0), 32'd0);
    if (mode != 0)
      chk("R9 start while busy ignored", 32'(errors - err0), 32'd0);
  endtask

  initial begin
    int hs[4];
    hs[0] = 0; hs[1] = 1; hs[2] = 2; hs[3] = 5;
    rst_n = 1'b0; start_i = 1'b0;
    n_i = '0; m_i = '0; v_i = 0; x_i = 0; r_i = '0; hold_i = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset sdata", 32'(sdata_o), 0);
    chk("R11 reset sclk", 32'(sclk_o), 0);
    chk("R11 reset load", 32'(load_o), 0);
    chk("R11 reset commit", 32'(commit_o), 0);
    chk("R11 reset busy", 32'(busy_o), 0);
    start_i = 1'b1;
    @(negedge clk);
    chk("R11 start ignored in reset", 32'(busy_o), 0);
    start_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    for (int hi = 0; hi < 4; hi++) begin
      run_xfer(7'h00, 7'h00, 1'b0, 1'b0, 2'b00, HOLD_W'(hs[hi]), 0);
      run_xfer(7'h7f, 7'h7f, 1'b1, 1'b1, 2'b11, HOLD_W'(hs[hi]), 3);
      for (int i = 0; i < 10; i++) begin
        logic [7:0] a, b;
        a = 8'(i * 37 + hs[hi] * 11 + 5);
        b = 8'(i * 53 + 19);
        run_xfer(a[6:0], b[6:0], i[0], i[1], 2'(i >> 2), HOLD_W'(hs[hi]), i % 4);
        if (i == 4) @(negedge clk);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule